// File: doc/BRIEF.md
# Pseudo-Random Pattern Receive Lock Monitor

This block watches a received serial bit stream for a maximal-length pseudo-random test pattern of either period 2^15-1 or period 2^20-1. It predicts each incoming bit from a local reference history and compares the prediction with the received bit. While it is out of lock, the reference is filled from the incoming bits, so that it aligns itself to the pattern with no seed and no handshake. Once it is in lock, the reference runs on its own, so a corrupted received bit shows up as exactly one mismatch.

Lock is judged over consecutive blocks of 64 valid bits. Mismatches are also totalled into a saturating 16-bit error counter. A sticky interrupt status bit records lock transitions, and a mask gates that bit onto the interrupt line. The block sits behind clock and data recovery: it accepts one bit per clock in which the valid strobe is high.

Top module: `prbs_sync_monitor`

## Requirements
- R1: After reset, locked_o, err_cnt_o, irq_stat_o and irq_o are all 0.
- R2: With pat_long_i=0, the expected stream obeys b[n]=b[n-14]^b[n-15]. With pat_long_i=1, it obeys b[n]=b[n-17]^b[n-20]. An error-free stream of the selected kind sets locked_o by the end of the second full window. A stream of the other kind never sets it.
- R3: Windows are consecutive, non-overlapping runs of 64 valid bits, counted from reset. At the 64th bit of a window, locked_o becomes 1 if that window held 6 or fewer mismatches.
- R4: A window with 7 or more mismatches clears locked_o at its 64th valid bit and not before.
- R5: With inv_i=1, the expected stream is the bitwise complement of the R2 pattern. A complemented stream checked with inv_i=0 mismatches on every bit once the reference is full.
- R6: With cnt_sel_i==2'b00, err_cnt_o increments by one per mismatching valid bit. With any other cnt_sel_i value, err_cnt_o holds.
- R7: err_cnt_o saturates at 16'hFFFF.
- R8: A 0-to-1 change of locked_o sets irq_stat_o one cycle later. A 1-to-0 change sets it only when any_edge_i=1.
- R9: irq_o is 1 exactly when irq_stat_o=1 and irq_mask_i=1.
- R10: A clr_i pulse sets err_cnt_o to 0 on the next cycle and clears irq_stat_o. A lock event in the same cycle as clr_i still sets irq_stat_o.
- R11: Cycles with bit_vld_i=0 change neither the window position, the lock state nor the counter, whatever bit_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | bit_i carries a valid bit this cycle |
| pat_long_i | input | 1 | 0: period 2^15-1, 1: period 2^20-1 |
| inv_i | input | 1 | Expect the complemented pattern |
| cnt_sel_i | input | 2 | 2'b00 routes mismatches into the error counter |
| any_edge_i | input | 1 | 1: both lock transitions set the status bit; 0: only gaining lock does |
| irq_mask_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Clears the error counter and the interrupt status |
| locked_o | output | 1 | Pattern lock status |
| err_cnt_o | output | 16 | Saturating mismatch count |
| irq_stat_o | output | 1 | Sticky lock-change status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that every control input is driven to a known level from the first clock after reset, and that clr_i is a short pulse. They also assume that pat_long_i and inv_i change only together with a reset, because a mid-stream change would make the window behaviour undefined. The bench drives all inputs before reset is released and changes the pattern controls only around a reset. It pulses clr_i only while bit_vld_i is low, and it tracks the valid-bit count from reset, so it always knows where each 64-bit window starts and ends.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  typedef enum logic [1:0] {
    CNT_PATTERN = 2'b00,
    CNT_OTHER1  = 2'b01,
    CNT_OTHER2  = 2'b10,
    CNT_OTHER3  = 2'b11
  } cnt_sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } lock_evt_t;
endpackage

// File: rtl/prbs_ref.sv
module prbs_ref #(
  parameter int unsigned SHORT_ORD = 15,
  parameter int unsigned SHORT_TAP = 14,
  parameter int unsigned LONG_ORD  = 20,
  parameter int unsigned LONG_TAP  = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  input  logic pat_long_i,
  input  logic inv_i,
  input  logic locked_i,
  output logic mismatch_o
);
  localparam int unsigned HIST_W = (LONG_ORD > SHORT_ORD) ? LONG_ORD : SHORT_ORD;

  logic [HIST_W-1:0] hist_q;
  logic              data_in;
  logic              pred;
  logic              pred_short;
  logic              pred_long;

  assign data_in    = bit_i ^ inv_i;
  assign pred_short = hist_q[SHORT_ORD-1] ^ hist_q[SHORT_TAP-1];
  assign pred_long  = hist_q[LONG_ORD-1] ^ hist_q[LONG_TAP-1];
  assign pred       = pat_long_i ? pred_long : pred_short;
  assign mismatch_o = bit_vld_i & (data_in ^ pred);

  // out of lock: load received bits (self-sync); in lock: free-run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (bit_vld_i) begin
      hist_q <= {hist_q[HIST_W-2:0], locked_i ? pred : data_in};
    end
  end
endmodule

// File: rtl/lock_judge.sv
module lock_judge #(
  parameter int unsigned WIN_LEN = 64,
  parameter int unsigned ERR_MAX = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic mismatch_i,
  output logic locked_o
);
  localparam int unsigned WIN_W = $clog2(WIN_LEN);
  localparam int unsigned TAL_W = WIN_W + 1;

  logic [WIN_W-1:0] win_q;
  logic [TAL_W-1:0] tally_q;
  logic [TAL_W-1:0] tally_sum;
  logic             win_end;
  logic             locked_q;

  assign tally_sum = tally_q + TAL_W'(mismatch_i);
  assign win_end   = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      tally_q  <= '0;
      locked_q <= 1'b0;
    end else if (bit_vld_i) begin
      if (win_end) begin
        win_q    <= '0;
        tally_q  <= '0;
        locked_q <= (tally_sum <= TAL_W'(ERR_MAX));
      end else begin
        win_q    <= win_q + 1'b1;
        tally_q  <= tally_sum;
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/err_counter.sv
module err_counter
  import prbs_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mismatch_i,
  input  logic [1:0]       cnt_sel_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc = mismatch_i && (cnt_sel_e'(cnt_sel_i) == CNT_PATTERN) && (cnt_q != CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import prbs_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic locked_i,
  input  logic any_edge_i,
  input  logic irq_mask_i,
  input  logic clr_i,
  output logic stat_o,
  output logic irq_o
);
  logic      prev_q;
  logic      stat_q;
  lock_evt_t evt;
  logic      set_ev;

  assign evt.rise = locked_i & ~prev_q;
  assign evt.fall = ~locked_i & prev_q;
  assign set_ev   = evt.rise | (evt.fall & any_edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= locked_i;
      if (set_ev)     stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & irq_mask_i;
endmodule

// File: rtl/prbs_sync_monitor.sv
module prbs_sync_monitor #(
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_MAX   = 6,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SHORT_ORD = 15,
  parameter int unsigned SHORT_TAP = 14,
  parameter int unsigned LONG_ORD  = 20,
  parameter int unsigned LONG_TAP  = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             pat_long_i,
  input  logic             inv_i,
  input  logic [1:0]       cnt_sel_i,
  input  logic             any_edge_i,
  input  logic             irq_mask_i,
  input  logic             clr_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             irq_stat_o,
  output logic             irq_o
);
  logic mismatch;
  logic locked;

  prbs_ref #(
    .SHORT_ORD(SHORT_ORD), .SHORT_TAP(SHORT_TAP),
    .LONG_ORD (LONG_ORD),  .LONG_TAP (LONG_TAP)
  ) u_ref (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i, .pat_long_i, .inv_i,
    .locked_i  (locked),
    .mismatch_o(mismatch)
  );

  lock_judge #(.WIN_LEN(WIN_LEN), .ERR_MAX(ERR_MAX)) u_judge (
    .clk_i, .rst_ni, .bit_vld_i,
    .mismatch_i(mismatch),
    .locked_o  (locked)
  );

  err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .cnt_sel_i, .clr_i,
    .mismatch_i(mismatch),
    .cnt_o     (err_cnt_o)
  );

  irq_latch u_irq (
    .clk_i, .rst_ni, .any_edge_i, .irq_mask_i, .clr_i,
    .locked_i(locked),
    .stat_o  (irq_stat_o),
    .irq_o   (irq_o)
  );

  assign locked_o = locked;
endmodule

// File: rtl/prbs_mon_chk.sv
module prbs_mon_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_i,
  input logic [1:0]       cnt_sel_i,
  input logic             irq_mask_i,
  input logic             clr_i,
  input logic             locked_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             irq_stat_o,
  input logic             irq_o
);
  p_rise_sets_stat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |=> irq_stat_o);

  p_irq_needs_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> irq_mask_i);

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == {CNT_W{1'b1}} && !clr_i) |=> err_cnt_o == {CNT_W{1'b1}});

  p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_sel_i != 2'b00 && !clr_i) |=> $stable(err_cnt_o));

  p_clr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> err_cnt_o == '0);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !clr_i) |=> ($stable(locked_o) && $stable(err_cnt_o)));

  p_lock_needs_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(locked_o));
endmodule

bind prbs_sync_monitor prbs_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .bit_vld_i, .cnt_sel_i, .irq_mask_i, .clr_i,
  .locked_o, .err_cnt_o, .irq_stat_o, .irq_o
);

// File: tb/prbs_sync_monitor_test.sv
`timescale 1ns/1ps
module prbs_sync_monitor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_vld_i = 1'b0;
  logic        pat_long_i = 1'b0;
  logic        inv_i = 1'b0;
  logic [1:0]  cnt_sel_i = 2'b00;
  logic        any_edge_i = 1'b0;
  logic        irq_mask_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        locked_o;
  logic [15:0] err_cnt_o;
  logic        irq_stat_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int nbits  = 0;
  logic [19:0] gen = 20'h00001;
  logic        gen_long = 1'b0;
  logic        gen_inv = 1'b0;

  always #2.5 clk = ~clk;

  prbs_sync_monitor uut (
    .clk_i(clk), .rst_ni, .bit_i, .bit_vld_i, .pat_long_i, .inv_i, .cnt_sel_i,
    .any_edge_i, .irq_mask_i, .clr_i, .locked_o, .err_cnt_o, .irq_stat_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    bit_vld_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    nbits = 0;
    gen = 20'h00001;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld_i = 1'b0;
      bit_i = ~bit_i;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b;
    bit_vld_i = 1'b1;
    nbits++;
  endtask

  function automatic logic next_pat();
    logic b;
    b = gen_long ? (gen[19] ^ gen[16]) : (gen[14] ^ gen[13]);
    gen = {gen[18:0], b};
    return b ^ gen_inv;
  endfunction

  // send n pattern bits, corrupting the first nerr (spaced by 5)
  task automatic send_pat(input int n, input int nerr, input int gap);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = next_pat();
      if (i % 5 == 0 && i / 5 < nerr) b = ~b;
      send_bit(b);
      if (gap > 0) idle(gap);
    end
    idle(2);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    bit_vld_i = 1'b0;
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    idle(2);
    check("R1 locked", locked_o, 0);
    check("R1 count", err_cnt_o, 0);
    check("R1 stat", irq_stat_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_lock15();
    irq_mask_i = 1'b1;
    send_pat(128, 0, 0);
    check("R2 lock short", locked_o, 1);
    check("R8 rise stat", irq_stat_o, 1);
    check("R9 irq masked on", irq_o, 1);
    pulse_clr();
    check("R10 clr stat", irq_stat_o, 0);
    check("R10 clr count", err_cnt_o, 0);
  endtask

  task automatic t_six();
    send_pat(64, 6, 0);
    check("R3 six keeps lock", locked_o, 1);
    check("R6 count six", err_cnt_o, 6);
  endtask

  task automatic t_seven();
    send_pat(63, 7, 0);
    check("R4 not before end", locked_o, 1);
    send_pat(1, 0, 0);
    check("R4 lock lost", locked_o, 0);
    check("R8 fall ignored", irq_stat_o, 0);
    check("R6 count thirteen", err_cnt_o, 13);
    send_pat(64, 0, 0);
    check("R3 relock", locked_o, 1);
    check("R8 relock stat", irq_stat_o, 1);
    check("R6 no new errors", err_cnt_o, 13);
  endtask

  task automatic t_any_edge();
    pulse_clr();
    any_edge_i = 1'b1;
    irq_mask_i = 1'b0;
    send_pat(64, 7, 0);
    check("R4 lost again", locked_o, 0);
    check("R8 fall sets stat", irq_stat_o, 1);
    check("R9 masked off", irq_o, 0);
    irq_mask_i = 1'b1;
    idle(1);
    check("R9 unmasked", irq_o, 1);
    send_pat(64, 0, 0);
    check("R3 relock any", locked_o, 1);
    pulse_clr();
    any_edge_i = 1'b0;
    check("R10 stat cleared", irq_stat_o, 0);
  endtask

  task automatic t_sel();
    cnt_sel_i = 2'b01;
    send_pat(64, 3, 0);
    check("R6 sel other holds", err_cnt_o, 0);
    check("R3 three keeps lock", locked_o, 1);
    cnt_sel_i = 2'b00;
  endtask

  task automatic t_gap();
    send_pat(64, 0, 2);
    check("R11 gaps keep lock", locked_o, 1);
    check("R11 gaps no count", err_cnt_o, 0);
    check("R11 gaps no stat", irq_stat_o, 0);
  endtask

  task automatic t_long_inv();
    gen_long = 1'b1; gen_inv = 1'b1;
    pat_long_i = 1'b1; inv_i = 1'b1;
    do_reset();
    send_pat(128, 0, 0);
    check("R5 inverted long lock", locked_o, 1);
    pulse_clr();
    send_pat(64, 2, 0);
    check("R5 inverted count", err_cnt_o, 2);
    inv_i = 1'b0;
    do_reset();
    send_pat(128, 0, 0);
    check("R5 wrong polarity", locked_o, 0);
    check("R5 wrong polarity errors", {31'd0, err_cnt_o >= 16'd64}, 1);
    gen_long = 1'b0; gen_inv = 1'b0;
    do_reset();
    send_pat(192, 0, 0);
    check("R2 wrong standard", locked_o, 0);
    pat_long_i = 1'b0;
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 65600; i++) send_bit(1'b1);
    idle(2);
    check("R7 saturate", err_cnt_o, 16'hFFFF);
    check("R3 ones never lock", locked_o, 0);
    pulse_clr();
    check("R10 clr after sat", err_cnt_o, 0);
  endtask

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_lock15();
    t_six();
    t_seven();
    t_any_edge();
    t_sel();
    t_gap();
    t_long_inv();
    t_sat();
    finish_run();
  end
endmodule